// File: doc/BRIEF.md
# GPIO Port with Interrupt Capture

This block is a 32-pin general-purpose I/O port that a host controls through a small synchronous register bus. The bus carries an address, a write strobe and write data. Read data is combinational from the current address, so a read completes in the same cycle. Every register bit maps to the pin with the same index. The port drives a pad output vector and an output-enable vector. It also brings the pad inputs into the clock domain through a two-flop synchronizer.

Each pin has its own interrupt detector. The host picks edge or level sensing, rising/high or falling/low polarity, and an any-edge mode for every pin separately. Detected events set pending bits in a capture register, and the host clears them by writing ones. An enable mask, changed only through set and clear aliases, gates the pending bits onto one combined interrupt request line. The output and direction registers also have set and clear aliases, so firmware can change single pins without a read-modify-write sequence.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is asserted and right after it, every register reads zero and `pin_out`, `pin_oe` and `irq` are zero.
- R2: A write to 0x00 loads the output data register and a write to 0x08 loads the direction register. Both read back at the same offsets. `pin_out` follows the output register and `pin_oe` follows the direction register (1 = drive, 0 = input). Nothing changes these two registers unless a write hits them.
- R3: The aliases are output-set 0x40, output-clear 0x44, direction-set 0x48, direction-clear 0x4C, enable-set 0x30 and enable-clear 0x34. Each one changes only the bits written as 1. Reads of these offsets, and of any unmapped offset, return zero.
- R4: Offset 0x04 reads the pin inputs after two synchronizer flops, in either direction. A pin change driven before a clock edge is readable after the second edge that follows. Writes to 0x04 have no effect.
- R5: For a pin whose bit is 0 in sense config (0x2C), in polarity (0x18) and in any-edge (0x1C), a rising edge of the synchronized input sets its pending bit in 0x20. The bit is set on the clock edge after the synchronized value changes.
- R6: A polarity bit of 1 at 0x18 makes an edge-mode pin capture falling edges instead of rising edges.
- R7: An any-edge bit of 1 at 0x1C makes an edge-mode pin capture both edges, whatever its polarity bit.
- R8: A sense-config bit of 1 at 0x2C selects level mode. The pending bit is set on every cycle the active level is present (high for polarity 0, low for polarity 1).
- R9: Writing 1s to 0x20 clears those pending bits, and bits written as 0 stay as they are. If a capture and a clear hit the same bit in one cycle, the capture wins.
- R10: `irq` is the OR of all pending bits whose enable bit is set. Pending bits are captured whether or not the pin is enabled. The enable mask has no readable offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Asynchronous pad inputs |
| pin_out | output | 32 | Pad output values |
| pin_oe | output | 32 | Pad output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench drives each sense mode through its edges. It checks that a wrong polarity decode captures on the opposite edge, and that an any-edge pin does not miss its falling edge. In level mode the bench clears while the level is still held. A design that let the clear win over a same-cycle capture would drop the pending bit for one cycle and then set it again, and the per-cycle comparison catches that one-cycle gap. A long random phase mixes alias writes with pin noise. It exposes aliases that overwrite instead of merging, and readable write-only offsets. It also catches pending bits that are gated by the enable mask instead of being captured regardless of it.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    parameter int unsigned PORT_PINS = 32;

    typedef logic [PORT_PINS-1:0] pinvec_t;

    // register byte offsets
    localparam int unsigned OFF_DOUT    = 'h00;
    localparam int unsigned OFF_DIN     = 'h04;
    localparam int unsigned OFF_DIR     = 'h08;
    localparam int unsigned OFF_POL     = 'h18;
    localparam int unsigned OFF_ANYEDGE = 'h1C;
    localparam int unsigned OFF_PEND    = 'h20;
    localparam int unsigned OFF_SENSE   = 'h2C;
    localparam int unsigned OFF_EN_SET  = 'h30;
    localparam int unsigned OFF_EN_CLR  = 'h34;
    localparam int unsigned OFF_OUT_SET = 'h40;
    localparam int unsigned OFF_OUT_CLR = 'h44;
    localparam int unsigned OFF_DIR_SET = 'h48;
    localparam int unsigned OFF_DIR_CLR = 'h4C;

    typedef struct packed {
        pinvec_t dout;
        pinvec_t dir;
        pinvec_t sense_lvl;
        pinvec_t pol_neg;
        pinvec_t any_edge;
        pinvec_t pend;
        pinvec_t en;
        pinvec_t prev;
    } port_state_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] chain_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= '0;
                else        chain_q[s] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= '0;
                else        chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] sense_lvl,
    input  logic [W-1:0] pol_neg,
    input  logic [W-1:0] any_edge,
    output logic [W-1:0] evt
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        logic rise, fall, lvl_hit, edge_hit;
        always_comb begin
            rise     = cur[i] & ~prev[i];
            fall     = ~cur[i] & prev[i];
            lvl_hit  = pol_neg[i] ? ~cur[i] : cur[i];
            edge_hit = any_edge[i] ? (rise | fall) : (pol_neg[i] ? fall : rise);
            evt[i]   = sense_lvl[i] ? lvl_hit : edge_hit;
        end
    end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_port_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [PORT_PINS-1:0] bus_wdata,
    output logic [PORT_PINS-1:0] bus_rdata,
    input  logic [PORT_PINS-1:0] pin_in,
    output logic [PORT_PINS-1:0] pin_out,
    output logic [PORT_PINS-1:0] pin_oe,
    output logic                 irq
);
    localparam logic [ADDR_W-1:0] A_DOUT    = ADDR_W'(OFF_DOUT);
    localparam logic [ADDR_W-1:0] A_DIN     = ADDR_W'(OFF_DIN);
    localparam logic [ADDR_W-1:0] A_DIR     = ADDR_W'(OFF_DIR);
    localparam logic [ADDR_W-1:0] A_POL     = ADDR_W'(OFF_POL);
    localparam logic [ADDR_W-1:0] A_ANYEDGE = ADDR_W'(OFF_ANYEDGE);
    localparam logic [ADDR_W-1:0] A_PEND    = ADDR_W'(OFF_PEND);
    localparam logic [ADDR_W-1:0] A_SENSE   = ADDR_W'(OFF_SENSE);
    localparam logic [ADDR_W-1:0] A_EN_SET  = ADDR_W'(OFF_EN_SET);
    localparam logic [ADDR_W-1:0] A_EN_CLR  = ADDR_W'(OFF_EN_CLR);
    localparam logic [ADDR_W-1:0] A_OUT_SET = ADDR_W'(OFF_OUT_SET);
    localparam logic [ADDR_W-1:0] A_OUT_CLR = ADDR_W'(OFF_OUT_CLR);
    localparam logic [ADDR_W-1:0] A_DIR_SET = ADDR_W'(OFF_DIR_SET);
    localparam logic [ADDR_W-1:0] A_DIR_CLR = ADDR_W'(OFF_DIR_CLR);

    port_state_t q, d;
    pinvec_t     pin_sync;
    pinvec_t     evt;
    pinvec_t     pend_clr;
    pinvec_t     pend_now;

    gpio_sync #(.W(PORT_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_evt_detect #(.W(PORT_PINS)) u_detect (
        .cur       (pin_sync),
        .prev      (q.prev),
        .sense_lvl (q.sense_lvl),
        .pol_neg   (q.pol_neg),
        .any_edge  (q.any_edge),
        .evt       (evt)
    );

    // next-state computation
    always_comb begin
        d        = q;
        d.prev   = pin_sync;
        pend_clr = (bus_we && bus_addr == A_PEND) ? bus_wdata : '0;
        // capture has priority over a same-cycle clear
        d.pend   = (q.pend & ~pend_clr) | evt;
        if (bus_we) begin
            case (bus_addr)
                A_DOUT:    d.dout      = bus_wdata;
                A_DIR:     d.dir       = bus_wdata;
                A_POL:     d.pol_neg   = bus_wdata;
                A_ANYEDGE: d.any_edge  = bus_wdata;
                A_SENSE:   d.sense_lvl = bus_wdata;
                A_EN_SET:  d.en        = q.en | bus_wdata;
                A_EN_CLR:  d.en        = q.en & ~bus_wdata;
                A_OUT_SET: d.dout      = q.dout | bus_wdata;
                A_OUT_CLR: d.dout      = q.dout & ~bus_wdata;
                A_DIR_SET: d.dir       = q.dir | bus_wdata;
                A_DIR_CLR: d.dir       = q.dir & ~bus_wdata;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // read mux
    always_comb begin
        case (bus_addr)
            A_DOUT:    bus_rdata = q.dout;
            A_DIN:     bus_rdata = pin_sync;
            A_DIR:     bus_rdata = q.dir;
            A_POL:     bus_rdata = q.pol_neg;
            A_ANYEDGE: bus_rdata = q.any_edge;
            A_PEND:    bus_rdata = q.pend;
            A_SENSE:   bus_rdata = q.sense_lvl;
            default:   bus_rdata = '0;
        endcase
    end

    assign pin_out  = q.dout;
    assign pin_oe   = q.dir;
    assign irq      = |(q.pend & q.en);
    assign pend_now = q.pend;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_port_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_we,
    input logic [PORT_PINS-1:0] bus_wdata,
    input logic [PORT_PINS-1:0] pin_out,
    input logic [PORT_PINS-1:0] pin_oe,
    input logic                 irq,
    input logic [PORT_PINS-1:0] pend,
    input logic [PORT_PINS-1:0] evt
);
    localparam logic [ADDR_W-1:0] C_PEND    = ADDR_W'(OFF_PEND);
    localparam logic [ADDR_W-1:0] C_EN_CLR  = ADDR_W'(OFF_EN_CLR);
    localparam logic [ADDR_W-1:0] C_OUT_SET = ADDR_W'(OFF_OUT_SET);
    localparam logic [ADDR_W-1:0] C_DIR_CLR = ADDR_W'(OFF_DIR_CLR);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(pin_out) && $stable(pin_oe)));

    // R3
    out_set_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == C_OUT_SET) |=> (pin_out == ($past(pin_out) | $past(bus_wdata))));

    // R3
    dir_clr_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == C_DIR_CLR) |=> (pin_oe == ($past(pin_oe) & ~$past(bus_wdata))));

    // R9
    capture_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> (($past(evt) & ~pend) == '0));

    // R9
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == C_PEND) |=> ((pend & $past(bus_wdata) & ~$past(evt)) == '0));

    // R10
    mask_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == C_EN_CLR && (&bus_wdata)) |=> !irq);
endmodule

bind gpio_irq_port gpio_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .pend      (pend_now),
    .evt       (evt)
);

// File: tb/gpio_irq_port_bench.sv
module gpio_irq_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [31:0]   pin_in = '0;
    logic [31:0]   pin_out, pin_oe;
    logic          irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_port #(.ADDR_W(AW)) u_gpio_irq_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_out = '0, m_dir = '0, m_lvl = '0, m_neg = '0;
    logic [31:0] m_any = '0, m_pend = '0, m_en = '0;
    logic [31:0] hist[$] = '{32'h0, 32'h0, 32'h0};
    logic [31:0] nxt_pend;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_out = '0; m_dir = '0; m_lvl = '0; m_neg = '0;
            m_any = '0; m_pend = '0; m_en = '0;
            hist = '{32'h0, 32'h0, 32'h0};
        end else begin
            nxt_pend = m_pend;
            if (bus_we && bus_addr == 8'h20)
                for (int i = 0; i < 32; i++) if (bus_wdata[i]) nxt_pend[i] = 1'b0;
            for (int i = 0; i < 32; i++) begin
                bit now, was, hit;
                now = hist[1][i];
                was = hist[2][i];
                if (m_lvl[i])      hit = m_neg[i] ? !now : now;
                else if (m_any[i]) hit = (now != was);
                else if (m_neg[i]) hit = was && !now;
                else               hit = now && !was;
                if (hit) nxt_pend[i] = 1'b1;
            end
            if (bus_we) begin
                case (bus_addr)
                    8'h00: m_out = bus_wdata;
                    8'h08: m_dir = bus_wdata;
                    8'h18: m_neg = bus_wdata;
                    8'h1C: m_any = bus_wdata;
                    8'h2C: m_lvl = bus_wdata;
                    8'h30: m_en  = m_en | bus_wdata;
                    8'h34: m_en  = m_en & ~bus_wdata;
                    8'h40: m_out = m_out | bus_wdata;
                    8'h44: m_out = m_out & ~bus_wdata;
                    8'h48: m_dir = m_dir | bus_wdata;
                    8'h4C: m_dir = m_dir & ~bus_wdata;
                    default: ;
                endcase
            end
            m_pend = nxt_pend;
            hist.push_front(pin_in);
            void'(hist.pop_back());
        end
    end

    function automatic logic [31:0] model_read(input logic [AW-1:0] a);
        case (a)
            8'h00: return m_out;
            8'h04: return hist[1];
            8'h08: return m_dir;
            8'h18: return m_neg;
            8'h1C: return m_any;
            8'h20: return m_pend;
            8'h2C: return m_lvl;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string read_tag(input logic [AW-1:0] a);
        case (a)
            8'h00, 8'h08: return "R2";
            8'h04: return "R4";
            8'h18: return "R6";
            8'h1C: return "R7";
            8'h2C: return "R8";
            8'h20: return "R9";
            default: return "R3";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at %0t: actual %h expected %h", req, what, $time, act, exp);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            check("R2", "pin_out", pin_out, m_out);
            check("R2", "pin_oe", pin_oe, m_dir);
            check("R10", "irq", {31'h0, irq}, {31'h0, |(m_pend & m_en)});
            check(read_tag(bus_addr), "bus_rdata", bus_rdata, model_read(bus_addr));
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] v);
        bus_addr = a; bus_wdata = v; bus_we = 1'b1;
        tick(1);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a);
        bus_addr = a;
        tick(1);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        tick(3);
        for (int a = 0; a < 'h50; a += 4) begin
            bus_addr = AW'(a);
            #1;
            check("R1", "reset rdata", bus_rdata, 32'h0);
        end
        check("R1", "reset outputs", {pin_out[15:0], pin_oe[15:0]} | {31'h0, irq}, 32'h0);
        bus_addr = '0;
        rst_n = 1'b1;
        tick(2);

        // R2: plain data and direction writes
        wr(8'h00, 32'hA5A5_0F0F);
        wr(8'h08, 32'hFFFF_0000);
        rd(8'h00); rd(8'h08);

        // R3: aliases merge only 1 bits, alias reads give zero
        wr(8'h40, 32'h0000_00F0);
        wr(8'h44, 32'h0500_0001);
        wr(8'h48, 32'h0000_0003);
        wr(8'h4C, 32'h8000_0001);
        rd(8'h40); rd(8'h44); rd(8'h48); rd(8'h4C); rd(8'h30); rd(8'h34); rd(8'h10);

        // R4: synchronized inputs regardless of direction; writes ignored
        bus_addr = 8'h04;
        pin_in = 32'h1234_5678; tick(1);
        pin_in = 32'hFFFF_FFFF; tick(3);
        wr(8'h04, 32'h0);
        pin_in = 32'h0; tick(4);

        // R5: rising edge, default config
        wr(8'h30, 32'hFFFF_FFFF);
        bus_addr = 8'h20;
        pin_in[0] = 1'b1; tick(5);
        wr(8'h20, 32'h1); rd(8'h20);
        pin_in[0] = 1'b0; tick(4);

        // R6: negative polarity captures falling edge only
        wr(8'h18, 32'h2);
        bus_addr = 8'h20;
        pin_in[1] = 1'b1; tick(4);
        pin_in[1] = 1'b0; tick(4);
        wr(8'h20, 32'hFFFF_FFFF); rd(8'h20);

        // R7: any-edge, polarity ignored
        wr(8'h1C, 32'h4); wr(8'h18, 32'h6);
        bus_addr = 8'h20;
        pin_in[2] = 1'b1; tick(4);
        wr(8'h20, 32'h4);
        pin_in[2] = 1'b0; tick(4);
        wr(8'h20, 32'hFFFF_FFFF);

        // R8 and R9: level mode re-arms, capture beats clear
        wr(8'h2C, 32'h8);
        pin_in[3] = 1'b1; tick(4);
        wr(8'h20, 32'h8); rd(8'h20);
        wr(8'h20, 32'h8);
        pin_in[3] = 1'b0; tick(4);
        wr(8'h20, 32'h8); rd(8'h20); rd(8'h2C);

        // R10: captured while disabled, irq follows enable
        wr(8'h34, 32'hFFFF_FFFF);
        pin_in[4] = 1'b1; tick(4);
        rd(8'h20);
        wr(8'h30, 32'h10); tick(2);
        wr(8'h34, 32'h10); tick(2);
        wr(8'h20, 32'hFFFF_FFFF);

        // random mix of writes and pin noise
        for (int n = 0; n < 2000; n++) begin
            logic [AW-1:0] addrs[13];
            addrs = '{8'h00, 8'h04, 8'h08, 8'h18, 8'h1C, 8'h20, 8'h2C,
                      8'h30, 8'h34, 8'h40, 8'h44, 8'h48, 8'h4C};
            pin_in    = pin_in ^ ($urandom & $urandom);
            bus_addr  = addrs[$urandom_range(0, 12)];
            bus_wdata = $urandom;
            bus_we    = ($urandom_range(0, 2) == 0);
            tick(1);
        end
        bus_we = 1'b0;
        tick(2);
        finish_run();
    end
endmodule